// File: doc/BRIEF.md
# Output Compare and PWM Channel

One timer-driven output channel. Each clock it takes the count of one of two 16-bit time bases and compares it with one or two compare values. What happens on a match depends on the mode. In the single-match modes a match sets, clears or toggles the pin. In the dual-match modes one compare value opens a pulse and the other closes it, either once or on every timer lap. In the PWM modes the pin rises at each timer rollover and falls when the count reaches a duty value. That duty value is taken from the primary compare register only at rollover, so software can write the register at any time without glitching the current period.

One PWM variant watches an active-low fault input. A fault forces the pin low without waiting for a clock edge and latches a fault condition. The pin stays off until software rewrites the mode field. A compare interrupt pulses for one cycle on the events listed below. The timers themselves and any register bus sit outside the block: the channel sees the counts, a rollover strobe for the selected time base, and a control word held steady by its owner.

Top module: `oc_pwm_chan`

## Requirements
- R1: While reset is held and in the first cycle after it, `pin_out` and `cmp_irq` are 0.
- R2: Bit 3 of `ctrl` picks the time base. 0 compares `tmr_a` and 1 compares `tmr_b`. Changing only this bit does not re-initialise the channel.
- R3: Mode field `ctrl[2:0]` = 0 disables the channel: the pin is low and no interrupt is raised, whatever the counts.
- R4: Mode 1: a cycle in which the selected count equals `cmp_pri` makes the pin high from the next cycle on. That cycle also pulses `cmp_irq` for one cycle.
- R5: Mode 2: the pin is high from the cycle after the mode is written. A primary match drives it low and pulses `cmp_irq`.
- R6: Mode 3: every cycle with a primary match inverts the pin and pulses `cmp_irq`.
- R7: Modes 4 and 5 (dual match): a primary match drives the pin high. A secondary match (`cmp_sec`) drives it low, and pulses `cmp_irq` if the pin was high. If both match in the same cycle, the secondary match wins. Mode 5 repeats this on every lap.
- R8: Mode 4 (one-shot): once a pulse has ended, the pin stays low and further matches are ignored until the mode field changes.
- R9: Modes 6 and 7 (PWM): when `tb_wrap` is 1, the active duty is loaded from `cmp_pri` and the pin goes high if that value is nonzero. Otherwise a count equal to the active duty drives the pin low. A write to `cmp_pri` during a period has no effect until the next rollover.
- R10: PWM with a duty of zero keeps the pin low for the whole period.
- R11: Mode 7: `fault_n` = 0 forces `pin_out` low in the same cycle. It latches a fault and pulses `cmp_irq` once. The pin stays low after `fault_n` returns to 1. Mode 6 ignores `fault_n`.
- R12: A change of `ctrl[2:0]` re-initialises the channel in the next cycle. This clears the fault and the one-shot state and reloads the active duty from `cmp_pri`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl | input | 4 | [2:0] mode, [3] time-base select |
| tmr_a | input | 16 | Count of time base A |
| tmr_b | input | 16 | Count of time base B |
| cmp_pri | input | 16 | Primary compare / PWM duty value |
| cmp_sec | input | 16 | Secondary compare value |
| tb_wrap | input | 1 | Rollover strobe of the selected time base |
| fault_n | input | 1 | Active-low fault input (mode 7) |
| pin_out | output | 1 | Compare output pin |
| cmp_irq | output | 1 | One-cycle compare interrupt |

## Verification
The hardest state to reach from the ports is a PWM fault that has latched and whose input has since released. This has to be told apart both from a live fault, which gates the pin without waiting for a clock edge, and from a re-armed channel. The directed part of the bench trips the fault in the middle of a high phase and checks the pin before the next edge. It then releases the fault, drives another rollover to show the pin stays off, and leaves and re-enters the mode to show recovery. The random part draws small counts and compare values so that matches, rollovers, mode rewrites and fault pulses fall together in the same cycles. A bench model predicts every output on every cycle.

// File: rtl/oc_pwm_pkg.sv
package oc_pwm_pkg;

    localparam int SEL_BIT = 3;

    typedef enum logic [2:0] {
        OCM_OFF  = 3'd0,
        OCM_SET  = 3'd1,
        OCM_CLR  = 3'd2,
        OCM_TOG  = 3'd3,
        OCM_ONE  = 3'd4,
        OCM_CONT = 3'd5,
        OCM_PWM  = 3'd6,
        OCM_PWMF = 3'd7
    } oc_mode_e;

endpackage

// File: rtl/oc_match_unit.sv
module oc_match_unit #(
    parameter int TW = 16
) (
    input  logic [TW-1:0] tmr_a,
    input  logic [TW-1:0] tmr_b,
    input  logic          sel_b,
    input  logic [TW-1:0] cmp_pri,
    input  logic [TW-1:0] cmp_sec,
    input  logic [TW-1:0] duty_act,
    output logic          hit_pri,
    output logic          hit_sec,
    output logic          hit_duty
);
    logic [TW-1:0] tb_cnt;

    assign tb_cnt   = sel_b ? tmr_b : tmr_a;
    assign hit_pri  = (tb_cnt == cmp_pri);
    assign hit_sec  = (tb_cnt == cmp_sec);
    assign hit_duty = (tb_cnt == duty_act);
endmodule

// File: rtl/oc_mode_core.sv
module oc_mode_core
    import oc_pwm_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  oc_mode_e      mode_in,
    input  logic          hit_pri,
    input  logic          hit_sec,
    input  logic          hit_duty,
    input  logic          wrap,
    input  logic          fault_n,
    input  logic [TW-1:0] cmp_pri,
    output logic [TW-1:0] duty_act,
    output oc_mode_e      mode_q,
    output logic          pin_q,
    output logic          irq_q
);
    typedef struct packed {
        oc_mode_e      mode;
        logic          pin;
        logic          done;
        logic          flt;
        logic          irq;
        logic [TW-1:0] duty;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     is_pwm;
    logic     same_mode;

    assign is_pwm    = (st_q.mode == OCM_PWM) || (st_q.mode == OCM_PWMF);
    assign same_mode = (mode_in == st_q.mode);

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        if (!same_mode) begin
            st_d.mode = mode_in;
            st_d.pin  = (mode_in == OCM_CLR);
            st_d.done = 1'b0;
            st_d.flt  = 1'b0;
            st_d.duty = cmp_pri;
        end else begin
            unique case (st_q.mode)
                OCM_OFF: st_d.pin = 1'b0;
                OCM_SET: if (hit_pri) begin
                    st_d.pin = 1'b1;
                    st_d.irq = 1'b1;
                end
                OCM_CLR: if (hit_pri) begin
                    st_d.pin = 1'b0;
                    st_d.irq = 1'b1;
                end
                OCM_TOG: if (hit_pri) begin
                    st_d.pin = !st_q.pin;
                    st_d.irq = 1'b1;
                end
                OCM_ONE, OCM_CONT: if (!st_q.done) begin
                    if (hit_sec) begin
                        st_d.pin  = 1'b0;
                        st_d.irq  = st_q.pin;
                        st_d.done = st_q.pin && (st_q.mode == OCM_ONE);
                    end else if (hit_pri) begin
                        st_d.pin = 1'b1;
                    end
                end
                OCM_PWM, OCM_PWMF: begin
                    if (st_q.mode == OCM_PWMF && (st_q.flt || !fault_n)) begin
                        st_d.irq = !st_q.flt;
                        st_d.flt = 1'b1;
                        st_d.pin = 1'b0;
                    end else if (wrap) begin
                        st_d.duty = cmp_pri;
                        st_d.pin  = (cmp_pri != '0);
                    end else if (hit_duty) begin
                        st_d.pin = 1'b0;
                    end
                end
                default: st_d.pin = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: OCM_OFF, pin: 1'b0, done: 1'b0, flt: 1'b0,
                      irq: 1'b0, duty: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign duty_act = st_q.duty;
    assign mode_q   = st_q.mode;
    assign pin_q    = st_q.pin;
    assign irq_q    = st_q.irq;

    assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == OCM_OFF && mode_in == OCM_OFF) |=> (!st_q.pin && !st_q.irq));

    assert_oneshot_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.pin);

    assert_pwm_rise_at_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm && same_mode && !wrap) |=> !$rose(st_q.pin));

    assert_zero_duty_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (is_pwm && same_mode && wrap && cmp_pri == '0) |=> !st_q.pin);

    assert_fault_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flt && same_mode) |=> st_q.flt);

    assert_rewrite_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !same_mode |=> (!st_q.flt && !st_q.done));
endmodule

// File: rtl/oc_pwm_chan.sv
module oc_pwm_chan
    import oc_pwm_pkg::*;
#(
    parameter int TW = 16,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] ctrl,
    input  logic [TW-1:0] tmr_a,
    input  logic [TW-1:0] tmr_b,
    input  logic [TW-1:0] cmp_pri,
    input  logic [TW-1:0] cmp_sec,
    input  logic          tb_wrap,
    input  logic          fault_n,
    output logic          pin_out,
    output logic          cmp_irq
);
    logic          hit_pri, hit_sec, hit_duty;
    logic [TW-1:0] duty_act;
    oc_mode_e      mode_q;
    oc_mode_e      mode_in;
    logic          pin_q;

    assign mode_in = oc_mode_e'(ctrl[2:0]);

    oc_match_unit #(.TW(TW)) u_match (
        .tmr_a    (tmr_a),
        .tmr_b    (tmr_b),
        .sel_b    (ctrl[SEL_BIT]),
        .cmp_pri  (cmp_pri),
        .cmp_sec  (cmp_sec),
        .duty_act (duty_act),
        .hit_pri  (hit_pri),
        .hit_sec  (hit_sec),
        .hit_duty (hit_duty)
    );

    oc_mode_core #(.TW(TW)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_in  (mode_in),
        .hit_pri  (hit_pri),
        .hit_sec  (hit_sec),
        .hit_duty (hit_duty),
        .wrap     (tb_wrap),
        .fault_n  (fault_n),
        .cmp_pri  (cmp_pri),
        .duty_act (duty_act),
        .mode_q   (mode_q),
        .pin_q    (pin_q),
        .irq_q    (cmp_irq)
    );

    // a live fault gates the pin before the next edge (R11)
    assign pin_out = pin_q && !((mode_q == OCM_PWMF) && !fault_n);

    assert_live_fault_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == OCM_PWMF) && !fault_n) |-> !pin_out);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!pin_out && !cmp_irq));
endmodule

// File: tb/oc_pwm_chan_tb.sv
`timescale 1ns/1ps
module oc_pwm_chan_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  ctrl = '0;
    logic [15:0] tmr_a = '0, tmr_b = '0, cmp_pri = '0, cmp_sec = '0;
    logic        tb_wrap = 1'b0;
    logic        fault_n = 1'b1;
    logic        pin_out, cmp_irq;

    int n_chk = 0;
    int n_err = 0;
    bit done_run = 1'b0;

    always #2.5 clk = !clk;

    oc_pwm_chan u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .tmr_a(tmr_a), .tmr_b(tmr_b),
        .cmp_pri(cmp_pri), .cmp_sec(cmp_sec), .tb_wrap(tb_wrap),
        .fault_n(fault_n), .pin_out(pin_out), .cmp_irq(cmp_irq)
    );

    // reference model state
    logic [2:0]  m_mode = '0;
    logic        m_pin = 1'b0, m_done = 1'b0, m_flt = 1'b0, m_irq = 1'b0;
    logic [15:0] m_duty = '0;

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R8";
            3'd5: return "R7";
            3'd6: return "R9";
            default: return "R11";
        endcase
    endfunction

    function automatic logic exp_pin();
        return m_pin && !m_flt && !(m_mode == 3'd7 && !fault_n);
    endfunction

    task automatic model_step();
        logic [15:0] tb;
        logic mp, ms;
        tb = ctrl[3] ? tmr_b : tmr_a;
        mp = (tb == cmp_pri);
        ms = (tb == cmp_sec);
        m_irq = 1'b0;
        if (ctrl[2:0] != m_mode) begin
            m_mode = ctrl[2:0];
            m_pin = (ctrl[2:0] == 3'd2);
            m_done = 1'b0; m_flt = 1'b0; m_duty = cmp_pri;
        end else begin
            case (m_mode)
                3'd0: m_pin = 1'b0;
                3'd1: if (mp) begin m_pin = 1'b1; m_irq = 1'b1; end
                3'd2: if (mp) begin m_pin = 1'b0; m_irq = 1'b1; end
                3'd3: if (mp) begin m_pin = !m_pin; m_irq = 1'b1; end
                3'd4, 3'd5: if (!m_done) begin
                    if (ms) begin
                        m_irq = m_pin;
                        m_done = m_pin && (m_mode == 3'd4);
                        m_pin = 1'b0;
                    end else if (mp) m_pin = 1'b1;
                end
                default: begin
                    if (m_mode == 3'd7 && (m_flt || !fault_n)) begin
                        m_irq = !m_flt; m_flt = 1'b1; m_pin = 1'b0;
                    end else if (tb_wrap) begin
                        m_duty = cmp_pri; m_pin = (cmp_pri != 0);
                    end else if (tb == m_duty) m_pin = 1'b0;
                end
            endcase
        end
    endtask

    // one clock: model follows the sampled inputs, outputs compared after the edge
    task automatic tick();
        @(posedge clk);
        model_step();
        #1;
        chk(mode_tag(m_mode), pin_out, exp_pin());
        chk({mode_tag(m_mode), " irq"}, cmp_irq, m_irq);
    endtask

    task automatic lap(input int upto);
        for (int t = 0; t <= upto; t++) begin
            tmr_a = 16'(t);
            tick();
        end
    endtask

    initial begin
        void'($urandom(32'h0C5EED));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 pin", pin_out, 1'b0);
        chk("R1 irq", cmp_irq, 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R1 after", pin_out, 1'b0);

        // R2 / R4: select bit moves the compare onto timer B
        tmr_a = 16'd5; tmr_b = 16'd9; cmp_pri = 16'd9; ctrl = 4'b0001;
        tick(); tick();
        chk("R2 timer A unmatched", pin_out, 1'b0);
        ctrl = 4'b1001;
        tick();
        chk("R2 timer B matched", pin_out, 1'b1);
        chk("R4 irq", cmp_irq, 1'b1);

        // R3: disabled channel
        ctrl = 4'b0000; tick();
        cmp_pri = tmr_a; tick();
        chk("R3 pin", pin_out, 1'b0);
        chk("R3 irq", cmp_irq, 1'b0);

        // R5: entry high, match low
        ctrl = 4'b0010; tmr_a = 16'd1; cmp_pri = 16'd3; tick();
        chk("R5 entry high", pin_out, 1'b1);
        tmr_a = 16'd3; tick();
        chk("R5 match low", pin_out, 1'b0);
        chk("R5 irq", cmp_irq, 1'b1);

        // R6: toggle
        ctrl = 4'b0011; tmr_a = 16'd0; tick();
        tmr_a = 16'd3; tick();
        chk("R6 first toggle", pin_out, 1'b1);
        tick();
        chk("R6 second toggle", pin_out, 1'b0);

        // R7: continuous dual match
        ctrl = 4'b0101; cmp_pri = 16'd2; cmp_sec = 16'd4; tmr_a = 16'd0; tick();
        lap(2); chk("R7 rise", pin_out, 1'b1);
        lap(4); chk("R7 fall", pin_out, 1'b0); chk("R7 irq", cmp_irq, 1'b1);
        lap(2); chk("R7 repeats", pin_out, 1'b1);

        // R8 / R12: one-shot and rearm
        ctrl = 4'b0100; tmr_a = 16'd0; tick();
        lap(2); chk("R8 pulse", pin_out, 1'b1);
        lap(7);
        lap(2); chk("R8 no second pulse", pin_out, 1'b0);
        ctrl = 4'b0000; tick();
        ctrl = 4'b0100; tick();
        lap(2); chk("R12 one-shot rearmed", pin_out, 1'b1);

        // R9: duty latched at rollover
        ctrl = 4'b0110; cmp_pri = 16'd3; tick();
        tmr_a = 16'd0; tb_wrap = 1'b1; tick(); tb_wrap = 1'b0;
        chk("R9 high at wrap", pin_out, 1'b1);
        cmp_pri = 16'd5;
        tmr_a = 16'd3; tick();
        chk("R9 old duty ends period", pin_out, 1'b0);
        tmr_a = 16'd0; tb_wrap = 1'b1; tick(); tb_wrap = 1'b0;
        tmr_a = 16'd3; tick();
        chk("R9 new duty ignores 3", pin_out, 1'b1);
        tmr_a = 16'd5; tick();
        chk("R9 new duty at 5", pin_out, 1'b0);

        // R10: zero duty
        cmp_pri = 16'd0; tmr_a = 16'd0; tb_wrap = 1'b1; tick(); tb_wrap = 1'b0;
        chk("R10 low at wrap", pin_out, 1'b0);
        lap(6);
        chk("R10 low all period", pin_out, 1'b0);

        // R11: fault
        ctrl = 4'b0111; cmp_pri = 16'd4; tick();
        tmr_a = 16'd0; tb_wrap = 1'b1; tick(); tb_wrap = 1'b0;
        tmr_a = 16'd1; tick();
        chk("R11 high before fault", pin_out, 1'b1);
        fault_n = 1'b0; #1;
        chk("R11 pin low without edge", pin_out, 1'b0);
        tick();
        chk("R11 irq on trip", cmp_irq, 1'b1);
        fault_n = 1'b1; tick();
        tmr_a = 16'd0; tb_wrap = 1'b1; tick(); tb_wrap = 1'b0;
        chk("R11 stays off after release", pin_out, 1'b0);
        ctrl = 4'b0110; tick();
        tb_wrap = 1'b1; tick(); tb_wrap = 1'b0;
        fault_n = 1'b0; tmr_a = 16'd1; tick();
        chk("R11 mode 6 ignores fault", pin_out, 1'b1);
        fault_n = 1'b1;
        ctrl = 4'b0111; tick();
        tmr_a = 16'd0; tb_wrap = 1'b1; tick(); tb_wrap = 1'b0;
        chk("R12 fault cleared by rewrite", pin_out, 1'b1);

        // constrained random mix against the model
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 39) == 0) ctrl = 4'($urandom_range(0, 15));
            tmr_a   = 16'($urandom_range(0, 7));
            tmr_b   = 16'($urandom_range(0, 7));
            if ($urandom_range(0, 15) == 0) cmp_pri = 16'($urandom_range(0, 7));
            if ($urandom_range(0, 15) == 0) cmp_sec = 16'($urandom_range(0, 7));
            tb_wrap = ($urandom_range(0, 7) == 0);
            fault_n = ($urandom_range(0, 29) != 0);
            tick();
        end

        done_run = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done_run) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule